// File: doc/BRIEF.md
# Dual-Gain Pixel Readout Sequencer

This block drives the row-level control lines for one pixel readout and asks the column converter for each sample. A one-cycle start request begins a sequence: the reset gate pulses with the gain-select line held high, the reset level is converted a programmed number of times, a transfer gate pulse moves the collected charge, and the signal level is converted the same number of times. Every conversion strobe carries two tags: whether it samples a reset or a signal level, and which conversion gain is active.

In single-gain mode the gain-select line chooses the gain once the reset pulse ends. It stays high for low gain and drops for high gain, and it keeps that level to the end of the sequence. In dual-gain mode the block collects four tagged groups from one exposure. The reset level is read at high gain and then at low gain. After the transfer the signal level is read at high gain and then at low gain. With 2x2 charge binning all four transfer gates fire together; otherwise only the gate of the selected pixel fires. The mode, gain, binning, pixel and sample count are captured when a start is accepted. Pulse widths and the settling gaps are parameters counted in clock cycles.

Top module: `pix_rdout_seq`

## Requirements
- R1: An accepted start drives `rst_gate_o` high for exactly RST_CYC cycles, with `gain_sel_o` high in every one of those cycles. The first `conv_start_o` comes RST_CYC+SETTLE_CYC cycles after the first cycle of the reset pulse.
- R2: In single-gain mode (`dual_gain_i`=0), `gain_sel_o` follows `low_gain_i` after the reset pulse (1 = low gain, 0 = high gain) and holds that level through every conversion and the transfer pulse.
- R3: Each conversion group has `samp_m1_i`+1 strobes, so a code of 0 to 7 gives 1 to 8 samples. Single mode issues 2 groups and dual mode issues 4. All reset-level strobes come before the transfer pulse.
- R4: The transfer pulse lasts TX_CYC cycles. When `bin_en_i`=1 it drives `tx_gate_o`=4'b1111. Otherwise it drives only bit `pix_sel_i` of `tx_gate_o`. The reset gate is never high during a transfer pulse.
- R5: In dual-gain mode the groups run in this order: high-gain reset, low-gain reset, high-gain signal, low-gain signal. `gain_sel_o` is 0 during the transfer pulse.
- R6: `conv_is_sig_o` is 0 on reset-level strobes and 1 on signal-level strobes. `conv_low_gain_o` is 1 exactly when the strobe belongs to a low-gain group, and in that case `gain_sel_o` is also 1.
- R7: `conv_start_o` is a one-cycle pulse. A new strobe is issued only after `adc_done_i` has been seen for the previous one. An `adc_done_i` with no conversion pending has no effect.
- R8: `busy_o` is high from the cycle after an accepted start until the last conversion is done. A start that arrives while busy is ignored: there is no second reset pulse and no extra strobe.
- R9: While reset is asserted and just after it, all control outputs and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, acted on only while idle |
| dual_gain_i | input | 1 | 1 = read both gains |
| low_gain_i | input | 1 | Gain choice for single-gain mode (1 = low) |
| bin_en_i | input | 1 | 1 = fire all four transfer gates |
| pix_sel_i | input | 2 | Pixel whose transfer gate fires without binning |
| samp_m1_i | input | SAMP_W | Samples per group minus one |
| adc_done_i | input | 1 | Conversion finished pulse |
| rst_gate_o | output | 1 | Reset gate drive |
| gain_sel_o | output | 1 | Gain-select line (1 = low gain) |
| tx_gate_o | output | 4 | Transfer gate drives |
| conv_start_o | output | 1 | Conversion start strobe |
| conv_is_sig_o | output | 1 | Strobe tag: 1 = signal level |
| conv_low_gain_o | output | 1 | Strobe tag: 1 = low gain |
| busy_o | output | 1 | Sequence in progress |

## Verification
The checker assumes that the converter answers each strobe with exactly one `adc_done_i` pulse, arriving at least one cycle after the strobe, and that configuration inputs matter only in the cycle a start is accepted. The bench's converter model replies after a random 1 to 4 cycle delay and never answers twice. The bench also sends deliberately unmatched done pulses, but only during the reset pulse, when no conversion is pending. This tests that they are ignored without breaking the one-reply rule for real strobes. Repeated starts are placed inside the busy window, so the captured configuration is never disturbed.

// File: rtl/pix_rdout_pkg.sv
// Shared types for the pixel readout sequencer.
// Assumes a 2x2 shared pixel group, so there are four transfer gates.
package pix_rdout_pkg;
    localparam int NUM_TX = 4;
    localparam int SEL_W  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,      // reset gate pulse
        ST_RST_SET,  // settle after reset
        ST_GRP_A,    // reset level, first gain
        ST_SW1_SET,  // settle after switch to low gain (dual)
        ST_GRP_B,    // reset level, low gain (dual)
        ST_SW2_SET,  // settle after switch back to high gain (dual)
        ST_TX,       // transfer gate pulse
        ST_TX_SET,   // settle after transfer
        ST_GRP_C,    // signal level, first gain
        ST_SW3_SET,  // settle after switch to low gain (dual)
        ST_GRP_D     // signal level, low gain (dual)
    } seq_state_t;

    typedef struct packed {
        logic             dual;
        logic             low_gain;
        logic             bin;
        logic [SEL_W-1:0] sel;
    } seq_cfg_t;
endpackage

// File: rtl/pix_rdout_timer.sv
// Down-counter for pulse widths and settling gaps.
// Load with (length-1); expired_o is high in the final cycle of the interval.
// Assumes a load happens only in the cycle before a timed state begins.
module pix_rdout_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= len_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pix_rdout_sampler.sv
// Issues one group of conversion strobes with a done handshake.
// While go_i is high: strobe, wait for done, repeat until n_m1_i+1 are done.
// Assumes go_i falls in the cycle after grp_done_o; dropping go_i clears the state.
module pix_rdout_sampler #(
    parameter int SAMP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [SAMP_W-1:0] n_m1_i,
    input  logic              adc_done_i,
    output logic              conv_start_o,
    output logic              grp_done_o
);
    logic [SAMP_W-1:0] cnt_q;
    logic              wait_q;

    // Track whether a conversion is pending and how many have completed.
    always_ff @(posedge clk) begin
        if (!rst_n || !go_i) begin
            cnt_q  <= '0;
            wait_q <= 1'b0;
        end else if (!wait_q) begin
            wait_q <= 1'b1;
        end else if (adc_done_i) begin
            wait_q <= 1'b0;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign conv_start_o = go_i && !wait_q;
    assign grp_done_o   = go_i && wait_q && adc_done_i && (cnt_q == n_m1_i);
endmodule

// File: rtl/pix_rdout_seq.sv
// Row readout sequencer: reset pulse, reset-level conversions, transfer pulse,
// signal-level conversions. Single-gain or dual-gain, optional 2x2 binning.
// Assumes the converter answers each strobe with one adc_done_i pulse.
// Configuration is captured when a start is accepted.
module pix_rdout_seq
    import pix_rdout_pkg::*;
#(
    parameter int RST_CYC    = 3,
    parameter int TX_CYC     = 2,
    parameter int SETTLE_CYC = 2,
    parameter int MAX_SAMP   = 8,
    localparam int SAMP_W    = $clog2(MAX_SAMP),
    localparam int MAXC      = (RST_CYC > TX_CYC) ?
                               ((RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC) :
                               ((TX_CYC > SETTLE_CYC) ? TX_CYC : SETTLE_CYC),
    localparam int CNT_W     = $clog2(MAXC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dual_gain_i,
    input  logic              low_gain_i,
    input  logic              bin_en_i,
    input  logic [SEL_W-1:0]  pix_sel_i,
    input  logic [SAMP_W-1:0] samp_m1_i,
    input  logic              adc_done_i,
    output logic              rst_gate_o,
    output logic              gain_sel_o,
    output logic [NUM_TX-1:0] tx_gate_o,
    output logic              conv_start_o,
    output logic              conv_is_sig_o,
    output logic              conv_low_gain_o,
    output logic              busy_o
);
    seq_state_t        state_q, state_d;
    seq_cfg_t          cfg_q;
    logic [SAMP_W-1:0] n_m1_q;
    logic              tmr_exp, tmr_load, grp_done, samp_go;
    logic [CNT_W-1:0]  tmr_len;

    // Capture configuration when an idle sequencer accepts a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            n_m1_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            cfg_q  <= '{dual: dual_gain_i, low_gain: low_gain_i,
                        bin: bin_en_i, sel: pix_sel_i};
            n_m1_q <= samp_m1_i;
        end
    end

    // Step through the readout phases.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)  state_d = ST_RST;
            ST_RST:     if (tmr_exp)  state_d = ST_RST_SET;
            ST_RST_SET: if (tmr_exp)  state_d = ST_GRP_A;
            ST_GRP_A:   if (grp_done) state_d = cfg_q.dual ? ST_SW1_SET : ST_TX;
            ST_SW1_SET: if (tmr_exp)  state_d = ST_GRP_B;
            ST_GRP_B:   if (grp_done) state_d = ST_SW2_SET;
            ST_SW2_SET: if (tmr_exp)  state_d = ST_TX;
            ST_TX:      if (tmr_exp)  state_d = ST_TX_SET;
            ST_TX_SET:  if (tmr_exp)  state_d = ST_GRP_C;
            ST_GRP_C:   if (grp_done) state_d = cfg_q.dual ? ST_SW3_SET : ST_IDLE;
            ST_SW3_SET: if (tmr_exp)  state_d = ST_GRP_D;
            ST_GRP_D:   if (grp_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pick the length of the timed phase about to begin.
    always_comb begin
        unique case (state_d)
            ST_RST:  tmr_len = CNT_W'(RST_CYC - 1);
            ST_TX:   tmr_len = CNT_W'(TX_CYC - 1);
            ST_RST_SET, ST_SW1_SET, ST_SW2_SET, ST_TX_SET, ST_SW3_SET:
                     tmr_len = CNT_W'(SETTLE_CYC - 1);
            default: tmr_len = '0;
        endcase
    end
    assign tmr_load = (state_d != state_q);

    pix_rdout_timer #(.W(CNT_W)) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_exp)
    );

    assign samp_go = (state_q == ST_GRP_A) || (state_q == ST_GRP_B) ||
                     (state_q == ST_GRP_C) || (state_q == ST_GRP_D);

    pix_rdout_sampler #(.SAMP_W(SAMP_W)) smp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (samp_go),
        .n_m1_i       (n_m1_q),
        .adc_done_i   (adc_done_i),
        .conv_start_o (conv_start_o),
        .grp_done_o   (grp_done)
    );

    // Gain-select level per phase: high in reset, then by mode.
    always_comb begin
        unique case (state_q)
            ST_IDLE: gain_sel_o = 1'b0;
            ST_RST:  gain_sel_o = 1'b1;
            ST_SW1_SET, ST_GRP_B, ST_SW3_SET, ST_GRP_D:
                     gain_sel_o = 1'b1;
            default: gain_sel_o = cfg_q.dual ? 1'b0 : cfg_q.low_gain;
        endcase
    end

    // Transfer gate decode: all gates when binning, else the selected one.
    for (genvar g = 0; g < NUM_TX; g++) begin : g_tx
        assign tx_gate_o[g] = (state_q == ST_TX) &&
                              (cfg_q.bin || (cfg_q.sel == SEL_W'(g)));
    end

    assign rst_gate_o      = (state_q == ST_RST);
    assign conv_is_sig_o   = (state_q == ST_GRP_C) || (state_q == ST_GRP_D);
    assign conv_low_gain_o = gain_sel_o && samp_go;
    assign busy_o          = (state_q != ST_IDLE);
endmodule

// File: rtl/pix_rdout_seq_chk.sv
// Protocol checker for pix_rdout_seq, bound to every instance.
// Assumes each strobe gets exactly one adc_done_i pulse at least a cycle later.
module pix_rdout_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       adc_done_i,
    input logic       rst_gate_o,
    input logic       gain_sel_o,
    input logic [3:0] tx_gate_o,
    input logic       conv_start_o,
    input logic       conv_is_sig_o,
    input logic       conv_low_gain_o,
    input logic       busy_o
);
    logic pending_q, tx_seen_q;

    // Track a strobe that has not yet been answered.
    always_ff @(posedge clk) begin
        if (!rst_n)            pending_q <= 1'b0;
        else if (conv_start_o) pending_q <= 1'b1;
        else if (adc_done_i)   pending_q <= 1'b0;
    end

    // Remember whether this sequence has already transferred charge.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) tx_seen_q <= 1'b0;
        else if (|tx_gate_o)   tx_seen_q <= 1'b1;
    end

    AST_GAIN_HIGH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_gate_o |-> gain_sel_o);                                        // R1
    AST_RESET_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_gate_o) |-> $past(!busy_o && start_i));                  // R8
    AST_TX_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_gate_o) |-> (($countones(tx_gate_o) == 1) || (&tx_gate_o)));  // R4
    AST_TX_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_gate_o) |-> !rst_gate_o);                                     // R4
    AST_GAIN_STABLE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tx_gate_o) && $past(|tx_gate_o)) |-> $stable(gain_sel_o));      // R2
    AST_STROBE_WAITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> !pending_q);                                      // R7
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);                                   // R7
    AST_SIG_TAG_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (conv_is_sig_o == tx_seen_q));                    // R6
    AST_LOW_TAG_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && conv_low_gain_o) |-> gain_sel_o);                 // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rst_gate_o && (tx_gate_o == 4'b0) && !conv_start_o)); // R8
endmodule

bind pix_rdout_seq pix_rdout_seq_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .adc_done_i      (adc_done_i),
    .rst_gate_o      (rst_gate_o),
    .gain_sel_o      (gain_sel_o),
    .tx_gate_o       (tx_gate_o),
    .conv_start_o    (conv_start_o),
    .conv_is_sig_o   (conv_is_sig_o),
    .conv_low_gain_o (conv_low_gain_o),
    .busy_o          (busy_o)
);

// File: tb/pix_rdout_seq_tb_top.sv
`timescale 1ns/1ps
module pix_rdout_seq_tb_top;
    localparam int RST_CYC = 3;
    localparam int TX_CYC  = 2;
    localparam int SET_CYC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, dual_gain_i = 1'b0, low_gain_i = 1'b0, bin_en_i = 1'b0;
    logic [1:0] pix_sel_i = '0;
    logic [2:0] samp_m1_i = '0;
    logic       adc_done_i = 1'b0;
    logic       rst_gate_o, gain_sel_o, conv_start_o, conv_is_sig_o, conv_low_gain_o, busy_o;
    logic [3:0] tx_gate_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Monitor state
    int cyc = 0, conv_n = 0, i_rst = -1, i_conv = -1;
    int rst_runs = 0, rst_len = 0, rst_gs_bad = 0;
    int tx_runs = 0, tx_len = 0, tx_val_bad = 0, tx_gs_bad = 0, conv_before_tx = -1;
    int busy_bad = 0;
    bit prev_rst = 0, prev_tx = 0, pending = 0, spur_en = 0;
    int dly = 0;
    logic [3:0] tx_exp = '0;
    logic       gs_tx_exp = 1'b0;
    logic [1:0] tag_log [0:63];
    logic       gs_log  [0:63];

    always #2.5 clk = ~clk;

    pix_rdout_seq #(.RST_CYC(RST_CYC), .TX_CYC(TX_CYC), .SETTLE_CYC(SET_CYC), .MAX_SAMP(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dual_gain_i(dual_gain_i),
        .low_gain_i(low_gain_i), .bin_en_i(bin_en_i), .pix_sel_i(pix_sel_i),
        .samp_m1_i(samp_m1_i), .adc_done_i(adc_done_i), .rst_gate_o(rst_gate_o),
        .gain_sel_o(gain_sel_o), .tx_gate_o(tx_gate_o), .conv_start_o(conv_start_o),
        .conv_is_sig_o(conv_is_sig_o), .conv_low_gain_o(conv_low_gain_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected {is_sig, low_gain} tag of strobe j.
    function automatic logic [1:0] exp_tag(input bit dual, input bit lg, input int n, input int j);
        int grp;
        if (dual) begin
            grp = j / n;
            return {grp >= 2, grp[0]};
        end
        return {j >= n, lg};
    endfunction

    // Converter model and output monitor, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (adc_done_i) adc_done_i = 1'b0;
        else if (pending) begin
            dly--;
            if (dly == 0) begin adc_done_i = 1'b1; pending = 0; end
        end else if (spur_en && rst_gate_o) adc_done_i = 1'b1;
        if (rst_gate_o) begin
            if (!prev_rst) begin rst_runs++; if (i_rst < 0) i_rst = cyc; end
            rst_len++;
            if (!gain_sel_o) rst_gs_bad++;
        end
        prev_rst = rst_gate_o;
        if (tx_gate_o != 4'b0) begin
            if (!prev_tx) begin tx_runs++; conv_before_tx = conv_n; end
            tx_len++;
            if (tx_gate_o != tx_exp) tx_val_bad++;
            if (gain_sel_o != gs_tx_exp) tx_gs_bad++;
        end
        prev_tx = (tx_gate_o != 4'b0);
        if (conv_start_o) begin
            if (conv_n == 0) i_conv = cyc;
            if (conv_n < 64) begin
                tag_log[conv_n] = {conv_is_sig_o, conv_low_gain_o};
                gs_log[conv_n]  = gain_sel_o;
            end
            conv_n++;
            if (!busy_o) busy_bad++;
            pending = 1;
            dly = 1 + int'($urandom % 4);
        end
    end

    task automatic run_seq(input bit dual, input bit lg, input bit bin, input logic [1:0] sel,
                           input logic [2:0] m1, input bit dbl, input bit spur);
        int n, groups, guard, tbad, gbad;
        n = int'(m1) + 1;
        groups = dual ? 4 : 2;
        @(negedge clk);
        conv_n = 0; i_rst = -1; i_conv = -1; rst_runs = 0; rst_len = 0; rst_gs_bad = 0;
        tx_runs = 0; tx_len = 0; tx_val_bad = 0; tx_gs_bad = 0; conv_before_tx = -1; busy_bad = 0;
        tx_exp = bin ? 4'hF : (4'b1 << sel);
        gs_tx_exp = dual ? 1'b0 : lg;
        spur_en = spur;
        dual_gain_i = dual; low_gain_i = lg; bin_en_i = bin; pix_sel_i = sel; samp_m1_i = m1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // Scramble config inputs: must not matter after capture.
        dual_gain_i = ~dual; low_gain_i = ~lg; bin_en_i = ~bin; pix_sel_i = ~sel; samp_m1_i = ~m1;
        if (dbl) begin
            repeat (RST_CYC + SET_CYC + 1) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 5000) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
        spur_en = 0;
        chk(!busy_o, "R8 busy released", busy_o, 0);
        chk(busy_bad == 0, "R8 busy during strobes", busy_bad, 0);
        chk(rst_runs == 1, "R8 single reset pulse", rst_runs, 1);
        chk(rst_len == RST_CYC && rst_gs_bad == 0, "R1 reset width with gain high", rst_len, RST_CYC);
        chk(i_conv - i_rst == RST_CYC + SET_CYC, "R1 first strobe latency", i_conv - i_rst, RST_CYC + SET_CYC);
        chk(conv_n == groups * n, "R3 strobe count", conv_n, groups * n);
        chk(conv_before_tx == n * (dual ? 2 : 1), "R3 reset strobes before transfer", conv_before_tx, n * (dual ? 2 : 1));
        chk(tx_runs == 1 && tx_len == TX_CYC, "R4 transfer width", tx_len, TX_CYC);
        chk(tx_val_bad == 0, "R4 transfer gate pattern", tx_val_bad, 0);
        chk(tx_gs_bad == 0, dual ? "R5 gain low in transfer" : "R2 gain held in transfer", tx_gs_bad, 0);
        tbad = 0; gbad = 0;
        for (int j = 0; j < conv_n && j < 64; j++) begin
            if (tag_log[j] != exp_tag(dual, lg, n, j)) tbad++;
            if (gs_log[j] != exp_tag(dual, lg, n, j)[0]) gbad++;
        end
        chk(tbad == 0, dual ? "R5 R6 dual tag order" : "R6 single tags", tbad, 0);
        chk(gbad == 0, dual ? "R5 gain-select at strobes" : "R2 gain-select at strobes", gbad, 0);
    endtask

    initial begin
        void'($urandom(32'd1931));
        repeat (3) @(negedge clk);
        chk(!busy_o && !rst_gate_o && tx_gate_o == 0 && !conv_start_o && !gain_sel_o,
            "R9 outputs low in reset", {busy_o, rst_gate_o, conv_start_o, gain_sel_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rst_gate_o && tx_gate_o == 0 && !gain_sel_o,
            "R9 outputs low after reset", {busy_o, rst_gate_o, gain_sel_o}, 0);
        // Directed corners
        run_seq(0, 0, 0, 2'd0, 3'd0, 0, 0);   // R2 high gain, single sample
        run_seq(0, 1, 1, 2'd3, 3'd7, 0, 0);   // R2 low gain, 8 samples, binned
        run_seq(1, 0, 0, 2'd2, 3'd0, 0, 0);   // R5 dual, single sample
        run_seq(1, 0, 1, 2'd1, 3'd7, 0, 0);   // R5 dual, 8 samples
        run_seq(1, 1, 0, 2'd1, 3'd2, 1, 0);   // R8 start while busy
        run_seq(0, 0, 0, 2'd3, 3'd3, 0, 1);   // R7 unmatched done ignored
        // Constrained random
        for (int k = 0; k < 20; k++) begin
            run_seq(bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                    2'($urandom % 4), 3'($urandom % 8), bit'($urandom % 4 == 0),
                    bit'($urandom % 3 == 0));
        end
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule